// File: doc/BRIEF.md
# Shared Atomic Lock Bit

This block holds a single lock bit that several requesters share. Each requester has its own request port. On that port it can ask for an indivisible swap, which stores a new value and hands back the value the bit held just before. It can also ask for a plain store. A swap with new value 1 is the test-and-set that takes the lock. A store of 0 releases it. A requester spins by reissuing the test-and-set until the returned prior value is 0.

Requests that arrive in the same cycle are serialized by a rotating-priority arbiter, so at most one operation changes the bit per clock. A requester that is not granted holds its request and sees no response; it is not told that it lost. The grant is combinational in the request cycle. One cycle later the granted port receives a response pulse that carries the prior value, plus a flag that says whether that operation acquired the lock.

Top module: `tas_lock_reg`

## Requirements
- R1: After reset the lock bit reads 0, and no grant, response or acquire flag is active.
- R2: In any cycle `gnt` has at most one bit set, and only for a port whose `req_vld` is high.
- R3: A granted swap stores `req_val` of the granted port into the lock bit. In the next cycle `rsp_vld` pulses for that port, and `rsp_old` shows the lock value held in the grant cycle.
- R4: A granted plain store (`req_swap`=0) updates the lock bit the same way and also answers with a pulse and the prior value. Storing 0 releases the lock.
- R5: The arbiter searches ports in rising index order, starting one above the last granted port and wrapping from N-1 to 0. After reset the search starts at port 0.
- R6: A port that requests but is not granted gets no `rsp_vld` in the following cycle, and its request changes nothing.
- R7: Between two responses that report an acquisition, a store of 0 always takes effect. Two requesters never both win a held lock.
- R8: `rsp_acq` is set for the responding port only when the operation was a swap with new value 1 and the prior value was 0.
- R9: In a cycle with no request the lock bit keeps its value, and no response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | N | Per-port request, held until granted |
| req_swap | input | N | Per-port kind: 1 swap, 0 plain store |
| req_val | input | N | Per-port value to store |
| gnt | output | N | One-hot grant in the request cycle |
| rsp_vld | output | N | Response pulse one cycle after the grant |
| rsp_old | output | 1 | Lock value before the granted operation |
| rsp_acq | output | N | Responding port acquired the lock |
| lock_state | output | 1 | Current lock bit |

## Verification
The hardest case to reach from the ports is a free lock that all requesters attack in the same cycle, with the rotating pointer sitting at each possible position. Only that case shows that exactly one contender is told 0 and that the others keep stalling and then lose. The stimulus releases the lock and fires a test-and-set from every port in the next cycle, many times over. Between those bursts, random retrying swaps, stores and idle gaps move the pointer to every position.

// File: rtl/tas_lock_reg.sv
module tas_lock_reg #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_vld,
  input  logic [N-1:0] req_swap,
  input  logic [N-1:0] req_val,
  output logic [N-1:0] gnt,
  output logic [N-1:0] rsp_vld,
  output logic         rsp_old,
  output logic [N-1:0] rsp_acq,
  output logic         lock_state
);

  logic          lock_q;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win;
  logic          hit;

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr_q) + k) % N;
      if (!hit && req_vld[j]) begin
        hit = 1'b1;
        win = IW'(j);
      end
    end
  end

  assign gnt        = hit ? (N'(1) << win) : '0;
  assign lock_state = lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      ptr_q   <= '0;
      rsp_vld <= '0;
      rsp_old <= 1'b0;
      rsp_acq <= '0;
    end else begin
      rsp_vld <= gnt;
      if (hit) begin
        lock_q  <= req_val[win];
        ptr_q   <= (win == IW'(N-1)) ? '0 : win + 1'b1;
        rsp_old <= lock_q;
        rsp_acq <= gnt & {N{req_swap[win] & req_val[win] & ~lock_q}};
      end else begin
        rsp_acq <= '0;
      end
    end
  end

  logic owned_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        owned_q <= 1'b0;
    else if (|rsp_acq) owned_q <= 1'b1;
    else if (!lock_q)  owned_q <= 1'b0;
  end

  a_r2_grant_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req_vld) == '0));
  a_r3_prior_value: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_vld) |-> (rsp_old == $past(lock_q)));
  a_r6_resp_only_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_vld) |-> ((rsp_vld & ~$past(req_vld)) == '0));
  a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_acq) |-> !owned_q);
  a_r8_acq_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    ((rsp_acq & ~rsp_vld) == '0) && ((|rsp_acq) -> !rsp_old));
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld == '0) |=> ($stable(lock_q) && rsp_vld == '0));

endmodule

// File: tb/test_tas_lock_reg.sv
module test_tas_lock_reg;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req_vld = '0, req_swap = '0, req_val = '0;
  logic [N-1:0] gnt, rsp_vld, rsp_acq;
  logic rsp_old, lock_state;

  tas_lock_reg #(.N(N)) i_tas_lock_reg (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int m_lock = 0, m_ptr = 0, m_owned = 0;
  logic [N-1:0] e_vld = '0, e_acq = '0;
  logic e_old = 1'b0;
  logic [N-1:0] hold = '0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [N-1:0] v, input logic [N-1:0] s, input logic [N-1:0] d);
    int w;
    logic [N-1:0] eg;
    @(negedge clk);
    req_vld = v; req_swap = s; req_val = d;
    #1;
    chk(rsp_vld == e_vld, "R6 rsp_vld", rsp_vld, e_vld);
    if (|e_vld) chk(rsp_old == e_old, "R3 rsp_old", rsp_old, e_old);
    chk(rsp_acq == e_acq, "R8 rsp_acq", rsp_acq, e_acq);
    chk(lock_state == m_lock[0], "R4 lock_state", lock_state, m_lock);
    if (|rsp_acq) begin
      chk(m_owned == 0, "R7 second winner", 1, 0);
      m_owned = 1;
    end
    if (m_lock == 0) m_owned = 0;
    w = -1;
    for (int k = 0; k < N; k++)
      if (w < 0 && v[(m_ptr + k) % N]) w = (m_ptr + k) % N;
    eg = (w < 0) ? '0 : N'(1) << w;
    chk(gnt == eg, "R5 gnt", gnt, eg);
    hold = v & ~eg;
    e_vld = eg;
    if (w >= 0) begin
      e_old = m_lock[0];
      e_acq = (s[w] && d[w] && m_lock == 0) ? eg : '0;
      m_lock = d[w];
      m_ptr = (w + 1) % N;
    end else e_acq = '0;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] v, s, d;
    repeat (3) @(negedge clk);
    #1;
    chk(lock_state == 0 && gnt == 0 && rsp_vld == 0 && rsp_acq == 0, "R1 reset", lock_state, 0);
    rst_n = 1'b1;
    // R9 idle
    cyc('0, '0, '0); cyc('0, '0, '0);
    // R3 single acquire, R8 acq
    cyc(4'b0001, 4'b0001, 4'b0001); cyc('0, '0, '0);
    // R3 failed test-and-set from port 2
    cyc(4'b0100, 4'b0100, 4'b0100); cyc('0, '0, '0);
    // R4 release by plain store
    cyc(4'b0001, 4'b0000, 4'b0000); cyc('0, '0, '0);
    // R2 R5 R7 all contend on a free lock, losers stall and retry
    for (int r = 0; r < 40; r++) begin
      cyc(4'b1111, 4'b1111, 4'b1111);
      for (int q = 0; q < N; q++) cyc(hold, hold, hold);
      cyc(4'b0001 << (r % N), '0, '0);
      if (r % 3 == 0) cyc('0, '0, '0);
    end
    // general swap with value 0
    cyc(4'b0010, 4'b0010, 4'b0000); cyc('0, '0, '0);
    // random spinning, releases and idles
    for (int c = 0; c < 4000; c++) begin
      v = hold; s = req_swap; d = req_val;
      for (int i = 0; i < N; i++) begin
        if (!hold[i]) begin
          v[i] = ($urandom % 3) == 0;
          s[i] = ($urandom % 4) != 0;
          d[i] = s[i] ? (($urandom % 5) != 0) : 1'b0;
        end
      end
      cyc(v, s, d);
    end
    cyc('0, '0, '0); cyc('0, '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule